// File: doc/BRIEF.md
# Match/Overflow PWM Channel

This block produces one pulse-width-modulated pin from a free-running timebase. A binary counter, advanced only while a run input is held high, sweeps through every value of its width and then wraps to zero. A compare value held inside the block sets where the pin goes high in each sweep. The pin rises on the clock at which the counter reaches the compare value and falls on the clock at which the counter wraps. The compare value is therefore the count of low clocks in each period, and the high share is (2^W − compare) / 2^W.

Software loads the compare value as two half-width pieces over a small write port. Loading the lower half turns the comparator off. Loading the upper half turns it back on. This ordering means a new value cannot take effect while only half of it is written. With the comparator off, the pin never rises, which gives a 0% duty cycle.

Each match also sets a sticky flag. The flag drives an interrupt line when the interrupt enable is set, so software can time its updates to the period. The counter width is a parameter with a default of 16, and the write data port is half that width.

Top module: `pwm16_channel`

## Requirements
- R1: After reset, the counter reads 0, the pin is low, the match flag is 0, the compare enable is 0, and the interrupt is low.
- R2: While `run` is 1, the counter increases by one on every clock and wraps from all-ones to 0. While `run` is 0, it holds its value.
- R3: With the enable at 1 and compare value C, the pin is high exactly in the cycles in which the counter is at or above C. This gives 2^W − C high cycles in each 2^W-cycle period, and for C = all-ones it gives a single high cycle.
- R4: The pin goes low in the cycle in which the counter shows 0 after a wrap. The exception is C = 0: there the match and the wrap coincide, the match wins, and the pin stays high for the whole period.
- R5: A write to address 0 loads compare bits [W/2-1:0] and clears the enable. A write to address 1 loads bits [W-1:W/2] and sets the enable. The new enable is visible in the cycle after the write.
- R6: While the enable is 0, no match happens. The pin stays low after the next wrap, and the flag is not set.
- R7: A match sets the match flag in the same cycle in which the pin rises. A write to address 2 with data bit 0 = 0 clears the flag. A write with bit 0 = 1 leaves the flag as it is.
- R8: If a match and a flag-clear write fall on the same clock, the flag ends up set.
- R9: Every write to address 2 loads the interrupt enable from data bit 1. The interrupt output is high exactly while both the flag and the interrupt enable are 1.
- R10: While `run` is 0, the counter, the pin and the flag keep their values, even when the counter sits one below the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run | input | 1 | Timebase advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 = compare low half, 1 = compare high half, 2 = control |
| wr_data | input | CNT_W/2 | Write data |
| count_o | output | CNT_W | Current timebase value |
| cmp_en_o | output | 1 | Compare enable |
| match_flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Match interrupt |
| pwm_o | output | 1 | PWM pin output |

## Verification
Every result is registered once. A write or a match shows at the ports in the cycle after the clock edge that takes it, and the pin and the flag change in the same cycle as the counter value that caused them. The bench drives inputs and samples outputs on the falling edge. The clock edge between two falling edges is the only one a result needs, so each expected value is compared at the falling edge right after the stimulus. For the duty-cycle sweep, the bench waits until the counter reads 0 after an enabled wrap. It then compares the pin against counter ≥ C for a full 64-cycle period and counts the high cycles, for every compare value of a 6-bit configuration.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CMP_LO = 2'd0,
    ADR_CMP_HI = 2'd1,
    ADR_CTRL   = 2'd2
  } reg_addr_e;

  // control write data bit positions
  localparam int CTRL_FLAG_BIT  = 0;
  localparam int CTRL_IRQEN_BIT = 1;
endpackage

// File: rtl/pwm16_timebase.sv
module pwm16_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_next,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q;

  always_comb begin
    count_next = run ? count_q + CNT_W'(1) : count_q;
    wrap_evt   = run && (count_q == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (run) begin
      count_q <= count_next;
    end
  end

  assign count = count_q;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (count_q == $past(count_q) + CNT_W'(1)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count_q));
endmodule

// File: rtl/pwm16_cmpreg.sv
module pwm16_cmpreg
  import pwm16_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int HALF = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HALF-1:0]   wr_data,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              cmp_en
);
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             en_q, en_d;
  logic             lo_wr, hi_wr;

  always_comb begin
    lo_wr = wr_en && (reg_addr_e'(wr_addr) == ADR_CMP_LO);
    hi_wr = wr_en && (reg_addr_e'(wr_addr) == ADR_CMP_HI);
    cmp_d = cmp_q;
    en_d  = en_q;
    if (lo_wr) begin
      cmp_d[HALF-1:0] = wr_data;
      en_d            = 1'b0;   // half-written value must not match
    end
    if (hi_wr) begin
      cmp_d[CNT_W-1:HALF] = wr_data;
      en_d                = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      en_q  <= en_d;
    end
  end

  assign cmp_val = cmp_q;
  assign cmp_en  = en_q;

  p_lo_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> !cmp_en);

  p_hi_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> cmp_en);
endmodule

// File: rtl/pwm16_outstage.sv
module pwm16_outstage
  import pwm16_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int HALF = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [CNT_W-1:0] count_next,
  input  logic             wrap_evt,
  input  logic             ctl_wr,
  input  logic [HALF-1:0]  ctl_data,
  output logic             pwm,
  output logic             flag,
  output logic             irq
);
  logic match;
  logic pwm_q, pwm_d;
  logic flag_q, flag_d;
  logic irqen_q, irqen_d;
  logic clr_req;

  always_comb begin
    // compare against the value the counter is about to take, so the
    // pin changes in the same cycle the counter shows the match value
    match   = run && cmp_en && (count_next == cmp_val);
    clr_req = ctl_wr && !ctl_data[CTRL_FLAG_BIT];

    pwm_d = pwm_q;
    if (match) begin
      pwm_d = 1'b1;          // set beats clear when C == 0
    end else if (wrap_evt) begin
      pwm_d = 1'b0;
    end

    flag_d = flag_q;
    if (match) begin
      flag_d = 1'b1;         // match beats a same-cycle clear
    end else if (clr_req) begin
      flag_d = 1'b0;
    end

    irqen_d = ctl_wr ? ctl_data[CTRL_IRQEN_BIT] : irqen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q   <= 1'b0;
      flag_q  <= 1'b0;
      irqen_q <= 1'b0;
    end else begin
      pwm_q   <= pwm_d;
      flag_q  <= flag_d;
      irqen_q <= irqen_d;
    end
  end

  assign pwm  = pwm_q;
  assign flag = flag_q;
  assign irq  = flag_q && irqen_q;

  p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> pwm);

  p_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !match) |=> !pwm);

  p_no_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_en && !flag) |=> !flag || $past(clr_req) == 1'b0);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !match) |=> !flag);

  p_match_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match && clr_req) |=> flag);

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pwm));
endmodule

// File: rtl/pwm16_channel.sv
module pwm16_channel
  import pwm16_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int HALF = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HALF-1:0]   wr_data,
  output logic [CNT_W-1:0]  count_o,
  output logic              cmp_en_o,
  output logic              match_flag_o,
  output logic              irq_o,
  output logic              pwm_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] count_next;
  logic             wrap_evt;
  logic [CNT_W-1:0] cmp_val;
  logic             ctl_wr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign ctl_wr = wr_en && (reg_addr_e'(wr_addr) == ADR_CTRL);

  pwm16_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run        (run),
    .count      (count_o),
    .count_next (count_next),
    .wrap_evt   (wrap_evt)
  );

  pwm16_cmpreg #(.CNT_W(CNT_W)) u_cmpreg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cmp_val (cmp_val),
    .cmp_en  (cmp_en_o)
  );

  pwm16_outstage #(.CNT_W(CNT_W)) u_outstage (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run        (run),
    .cmp_en     (cmp_en_o),
    .cmp_val    (cmp_val),
    .count_next (count_next),
    .wrap_evt   (wrap_evt),
    .ctl_wr     (ctl_wr),
    .ctl_data   (wr_data),
    .pwm        (pwm_o),
    .flag       (match_flag_o),
    .irq        (irq_o)
  );

  p_stop_flag_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!run && !wr_en) |=> $stable(match_flag_o));
endmodule

// File: tb/pwm16_channel_bench.sv
module pwm16_channel_bench;
  localparam int W = 6;
  localparam int H = W / 2;
  localparam int P = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [H-1:0] wr_data = '0;
  logic [W-1:0] count_o;
  logic         cmp_en_o, match_flag_o, irq_o, pwm_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm16_channel #(.CNT_W(W)) u_pwm16_channel (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count_o(count_o), .cmp_en_o(cmp_en_o),
    .match_flag_o(match_flag_o), .irq_o(irq_o), .pwm_o(pwm_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // call at a falling edge; returns at the falling edge showing the effect
  task automatic wr(input logic [1:0] a, input int d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = H'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_count(input int v);
    do @(negedge clk); while (int'(count_o) != v);
  endtask

  task automatic load_cmp(input int c);
    wr(2'd0, c & ((1 << H) - 1));
    wr(2'd1, c >> H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int prev, bad, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 pwm", pwm_o, 0);
    chk("R1 flag", match_flag_o, 0);
    chk("R1 enable", cmp_en_o, 0);
    chk("R1 irq", irq_o, 0);

    // R2 counting and wrap
    run = 1'b1;
    bad = 0;
    prev = int'(count_o);
    for (int i = 0; i < P + 8; i++) begin
      @(negedge clk);
      if (int'(count_o) != ((prev + 1) % P)) bad++;
      prev = int'(count_o);
    end
    chk("R2 step errors", bad, 0);

    // R6 enable off since reset: pin low, no flag over a full period
    wait_count(0);
    bad = 0;
    for (int i = 0; i < P; i++) begin
      if (pwm_o || match_flag_o) bad++;
      @(negedge clk);
    end
    chk("R6 activity with enable off", bad, 0);

    // R5 half writes steer enable
    wr(2'd1, 0);
    chk("R5 high half sets enable", cmp_en_o, 1);
    wr(2'd0, 0);
    chk("R5 low half clears enable", cmp_en_o, 0);

    // R3/R4 sweep of every compare value
    for (int c = 0; c < P; c++) begin
      load_cmp(c);
      chk("R5 enable after pair", cmp_en_o, 1);
      wait_count(0);
      bad = 0;
      hi = 0;
      for (int i = 0; i < P; i++) begin
        if (i == 0) chk($sformatf("R4 pin at wrap C=%0d", c), pwm_o, (c == 0) ? 1 : 0);
        if (int'(pwm_o) != ((int'(count_o) >= c) ? 1 : 0)) bad++;
        hi += int'(pwm_o);
        @(negedge clk);
      end
      chk($sformatf("R3 shape errors C=%0d", c), bad, 0);
      chk($sformatf("R3 high cycles C=%0d", c), hi, P - c);
    end

    // R7 flag set by matches, clear by 0, write of 1 ignored
    chk("R7 flag after matches", match_flag_o, 1);
    wr(2'd0, 0);
    wr(2'd2, 0);
    chk("R7 clear", match_flag_o, 0);
    wr(2'd2, 1);
    chk("R7 write 1 no effect", match_flag_o, 0);
    wait_count(0);
    bad = 0;
    for (int i = 0; i < P; i++) begin
      if (pwm_o || match_flag_o) bad++;
      @(negedge clk);
    end
    chk("R6 no match after low-half write", bad, 0);

    // R7 rise together with pin
    load_cmp(20);
    wait_count(5);
    wr(2'd2, 0);
    wait_count(19);
    chk("R7 flag before match", match_flag_o, 0);
    chk("R3 pin before match", pwm_o, 0);
    @(negedge clk);
    chk("R7 flag on match", match_flag_o, 1);
    chk("R3 pin on match", pwm_o, 1);

    // R8 match and clear on the same clock
    wait_count(5);
    wr(2'd2, 0);
    chk("R8 precondition clear", match_flag_o, 0);
    wait_count(19);
    wr(2'd2, 0);
    chk("R8 count at match", count_o, 20);
    chk("R8 match wins", match_flag_o, 1);

    // R9 interrupt gating
    wr(2'd2, 2);
    chk("R9 irq after clear", irq_o, 0);
    wait_count(20);
    chk("R9 irq on match", irq_o, 1);
    wr(2'd2, 3);
    chk("R9 irq kept", irq_o, 1);
    wr(2'd2, 1);
    chk("R9 irq masked", irq_o, 0);
    chk("R9 flag still set", match_flag_o, 1);

    // R10 stop while high
    wait_count(30);
    run = 1'b0;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (int'(count_o) != 30 || pwm_o != 1'b1) bad++;
    end
    chk("R10 hold while high", bad, 0);
    run = 1'b1;
    @(negedge clk);
    wr(2'd2, 0);
    wait_count(19);
    run = 1'b0;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (int'(count_o) != 19 || pwm_o || match_flag_o) bad++;
    end
    chk("R10 no match while stopped", bad, 0);
    run = 1'b1;
    @(negedge clk);
    chk("R10 resume match pin", pwm_o, 1);
    chk("R10 resume count", count_o, 20);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule